// File: doc/BRIEF.md
# Receive Word Match Filter

This block watches the stream of words coming out of a serial receiver and compares each word against two configurable reference values. Every incoming word carries a valid strobe and a tag that marks the first word of a frame. A 3-bit mode input picks the comparison rule. The rule can look at the first word of a frame or at any word. It can accept either reference value, require a two-word sequence, or use the second reference value as a bit mask. When the rule is satisfied, a sticky match flag is raised. The flag stays set until a clear strobe arrives.

Words are normally forwarded one cycle after they arrive. In match-only mode, words are dropped while the flag is clear. The word that satisfies the rule is itself forwarded, and every word after it passes until the flag is cleared. The reference values and the mode come in as inputs. Storage for the forwarded words belongs to the surrounding receive path.

Top module: `rx_match_filter`

## Requirements
- R1: Mode values 0 and 1 disable matching; with either of them selected the match flag never rises.
- R2: Mode 2 sets the flag when a valid word tagged as start of frame equals refA or refB; untagged words never match in this mode.
- R3: Mode 3 sets the flag when any valid word equals refA or refB.
- R4: Mode 4 sets the flag when a start-of-frame word equals refA and the very next valid word (untagged) equals refB. A third or later word never completes the pair.
- R5: Mode 5 sets the flag when a valid word equal to refA is directly followed by a valid word equal to refB. The armed state drops on the next word whatever its value. A refA word that fails as the second word arms the pair again.
- R6: Mode 6 sets the flag when a start-of-frame word satisfies (word & refB) == (refA & refB).
- R7: Mode 7 applies the masked test of R6 to every valid word, tagged or not.
- R8: The match flag is visible one cycle after the hitting word and holds until clearMatch is high at a clock edge. A clear in the same cycle as a new hit leaves the flag set.
- R9: With matchOnly low, each valid word appears on wordOut with wordOutValid high exactly one cycle later. wordOutValid is low in every cycle that follows a cycle without an input word.
- R10: With matchOnly high, words arriving while the flag is clear are dropped (wordOutValid stays low). The word that causes the match and all words after it are forwarded.
- R11: After reset the match flag and wordOutValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordIn | input | DATA_W | Received word |
| wordValid | input | 1 | wordIn carries a word this cycle |
| sofIn | input | 1 | Word is the first of its frame |
| clearMatch | input | 1 | Clears the match flag |
| modeSel | input | 3 | Comparison mode, 0..7 |
| matchOnly | input | 1 | Drop words until the flag is set |
| refA | input | DATA_W | First reference value |
| refB | input | DATA_W | Second reference value / mask |
| wordOut | output | DATA_W | Forwarded word |
| wordOutValid | output | 1 | wordOut carries a word this cycle |
| matchFlag | output | 1 | Sticky match indication |

## Verification
Both results are due one clock edge after the input word: the flag update and the forwarded word are registered on the same edge that accepts the word. The bench drives each word on a falling edge and waits for the next rising edge. It then samples one time unit later, so each check reads the state that word produced. A clear-only cycle is inserted between table rows when a row asks for it. The two-word modes are walked as consecutive rows, so the armed state carries from one row to the next exactly as it would on the wire.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

  typedef enum logic [2:0] {
    MODE_OFF          = 3'd0,
    MODE_OFF_ALT      = 3'd1,
    MODE_FIRST_EITHER = 3'd2,
    MODE_ANY_EITHER   = 3'd3,
    MODE_FIRST_PAIR   = 3'd4,
    MODE_ANY_PAIR     = 3'd5,
    MODE_FIRST_MASKED = 3'd6,
    MODE_ANY_MASKED   = 3'd7
  } matchMode_e;

  // comparator results, datapath -> control
  typedef struct packed {
    logic eqA;
    logic eqB;
    logic maskEq;
  } cmpHits_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic forward;
  } fwdCtl_t;

endpackage

// File: rtl/rmf_datapath.sv
module rmf_datapath
  import rmf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wordIn,
  input  logic [DATA_W-1:0] refA,
  input  logic [DATA_W-1:0] refB,
  input  fwdCtl_t           ctl,
  output cmpHits_t          hits,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordOutValid
);

  logic [DATA_W-1:0] maskedWord;
  logic [DATA_W-1:0] maskedRef;

  assign maskedWord  = wordIn & refB;
  assign maskedRef   = refA & refB;
  assign hits.eqA    = (wordIn == refA);
  assign hits.eqB    = (wordIn == refB);
  assign hits.maskEq = (maskedWord == maskedRef);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut      <= '0;
      wordOutValid <= 1'b0;
    end else begin
      wordOutValid <= ctl.forward;
      if (ctl.forward) wordOut <= wordIn;
    end
  end

endmodule

// File: rtl/rmf_control.sv
module rmf_control
  import rmf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic       sofIn,
  input  logic       clearMatch,
  input  logic [2:0] modeSel,
  input  logic       matchOnly,
  input  cmpHits_t   hits,
  output fwdCtl_t    ctl,
  output logic       matchFlag
);

  matchMode_e mode;
  logic       pairArmed;
  logic       hitNow;
  logic       armNext;

  assign mode = matchMode_e'(modeSel);

  always_comb begin
    hitNow = 1'b0;
    unique case (mode)
      MODE_OFF, MODE_OFF_ALT: hitNow = 1'b0;
      MODE_FIRST_EITHER:      hitNow = sofIn & (hits.eqA | hits.eqB);
      MODE_ANY_EITHER:        hitNow = hits.eqA | hits.eqB;
      MODE_FIRST_PAIR:        hitNow = pairArmed & ~sofIn & hits.eqB;
      MODE_ANY_PAIR:          hitNow = pairArmed & hits.eqB;
      MODE_FIRST_MASKED:      hitNow = sofIn & hits.maskEq;
      MODE_ANY_MASKED:        hitNow = hits.maskEq;
      default:                hitNow = 1'b0;
    endcase
    hitNow = hitNow & wordValid;
  end

  // first-pair mode arms only on a tagged word; otherwise any refA word arms
  assign armNext = (mode == MODE_FIRST_PAIR) ? (sofIn & hits.eqA) : hits.eqA;

  assign ctl.forward = wordValid & (~matchOnly | matchFlag | hitNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairArmed <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      if (wordValid) pairArmed <= armNext;
      matchFlag <= (matchFlag & ~clearMatch) | hitNow;
    end
  end

endmodule

// File: rtl/rx_match_filter.sv
module rx_match_filter
  import rmf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wordIn,
  input  logic              wordValid,
  input  logic              sofIn,
  input  logic              clearMatch,
  input  logic [2:0]        modeSel,
  input  logic              matchOnly,
  input  logic [DATA_W-1:0] refA,
  input  logic [DATA_W-1:0] refB,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordOutValid,
  output logic              matchFlag
);

  cmpHits_t hits;
  fwdCtl_t  ctl;

  rmf_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .wordIn      (wordIn),
    .refA        (refA),
    .refB        (refB),
    .ctl         (ctl),
    .hits        (hits),
    .wordOut     (wordOut),
    .wordOutValid(wordOutValid)
  );

  rmf_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .sofIn     (sofIn),
    .clearMatch(clearMatch),
    .modeSel   (modeSel),
    .matchOnly (matchOnly),
    .hits      (hits),
    .ctl       (ctl),
    .matchFlag (matchFlag)
  );

endmodule

// File: rtl/rx_match_filter_checker.sv
module rx_match_filter_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] wordIn,
  input logic              wordValid,
  input logic              clearMatch,
  input logic [2:0]        modeSel,
  input logic              matchOnly,
  input logic [DATA_W-1:0] refA,
  input logic [DATA_W-1:0] wordOut,
  input logic              wordOutValid,
  input logic              matchFlag
);

  p_off_never_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel <= 3'd1 && !matchFlag) |=> !matchFlag);

  p_any_either_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && modeSel == 3'd3 && wordIn == refA) |=> matchFlag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !clearMatch) |=> matchFlag);

  p_flag_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearMatch && !wordValid) |=> !matchFlag);

  p_forward_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !matchOnly) |=> (wordOutValid && wordOut == $past(wordIn)));

  p_no_phantom_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> !wordOutValid);

  p_drop_while_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && matchOnly && !matchFlag && modeSel <= 3'd1) |=> !wordOutValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_reset_quiet_r11: assert (!matchFlag && !wordOutValid);
    end
  end

endmodule

bind rx_match_filter rx_match_filter_checker #(.DATA_W(DATA_W)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .wordIn      (wordIn),
  .wordValid   (wordValid),
  .clearMatch  (clearMatch),
  .modeSel     (modeSel),
  .matchOnly   (matchOnly),
  .refA        (refA),
  .wordOut     (wordOut),
  .wordOutValid(wordOutValid),
  .matchFlag   (matchFlag)
);

// File: tb/rx_match_filter_bench.sv
module rx_match_filter_bench;

  localparam int DATA_W = 32;
  localparam logic [31:0] REF_A = 32'h1234_5678;
  localparam logic [31:0] REF_B = 32'hFFFF_0000;
  localparam int NVEC = 24;

  // {clrFirst, mode[2:0], matchOnly, sof, word[31:0], expFlag, expValid}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 1'b1}, // R1
    {1'b0, 3'd1, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 1'b1}, // R1
    {1'b1, 3'd2, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b1}, // R2 untagged
    {1'b0, 3'd2, 1'b0, 1'b1, 32'hFFFF_0000, 1'b1, 1'b1}, // R2
    {1'b1, 3'd3, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R3
    {1'b0, 3'd3, 1'b0, 1'b0, 32'h1234_5678, 1'b1, 1'b1}, // R3
    {1'b1, 3'd4, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 1'b1}, // R4
    {1'b0, 3'd4, 1'b0, 1'b0, 32'hFFFF_0000, 1'b1, 1'b1}, // R4
    {1'b1, 3'd4, 1'b0, 1'b1, 32'h1234_5678, 1'b0, 1'b1}, // R4
    {1'b0, 3'd4, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b1}, // R4 wrong 2nd
    {1'b0, 3'd4, 1'b0, 1'b0, 32'hFFFF_0000, 1'b0, 1'b1}, // R4 third word
    {1'b1, 3'd5, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b1}, // R5
    {1'b0, 3'd5, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b1}, // R5 re-arm
    {1'b0, 3'd5, 1'b0, 1'b0, 32'hFFFF_0000, 1'b1, 1'b1}, // R5
    {1'b1, 3'd5, 1'b0, 1'b0, 32'h1234_5678, 1'b0, 1'b1}, // R5
    {1'b0, 3'd5, 1'b0, 1'b0, 32'h0000_0001, 1'b0, 1'b1}, // R5 disarm
    {1'b0, 3'd5, 1'b0, 1'b0, 32'hFFFF_0000, 1'b0, 1'b1}, // R5
    {1'b1, 3'd6, 1'b0, 1'b0, 32'h1234_ABCD, 1'b0, 1'b1}, // R6 untagged
    {1'b0, 3'd6, 1'b0, 1'b1, 32'h1234_ABCD, 1'b1, 1'b1}, // R6
    {1'b1, 3'd6, 1'b0, 1'b1, 32'h4321_ABCD, 1'b0, 1'b1}, // R6 miss
    {1'b1, 3'd7, 1'b0, 1'b0, 32'h1234_FFFF, 1'b1, 1'b1}, // R7
    {1'b1, 3'd3, 1'b1, 1'b0, 32'h0000_0005, 1'b0, 1'b0}, // R10 dropped
    {1'b0, 3'd3, 1'b1, 1'b0, 32'hFFFF_0000, 1'b1, 1'b1}, // R10 hit word
    {1'b0, 3'd3, 1'b1, 1'b0, 32'h0000_0007, 1'b1, 1'b1}  // R10 after
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] wordIn = '0;
  logic              wordValid = 1'b0;
  logic              sofIn = 1'b0;
  logic              clearMatch = 1'b0;
  logic [2:0]        modeSel = 3'd0;
  logic              matchOnly = 1'b0;
  logic [DATA_W-1:0] refA = REF_A;
  logic [DATA_W-1:0] refB = REF_B;
  logic [DATA_W-1:0] wordOut;
  logic              wordOutValid;
  logic              matchFlag;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_match_filter #(.DATA_W(DATA_W)) u_rx_match_filter (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .sofIn(sofIn), .clearMatch(clearMatch), .modeSel(modeSel),
    .matchOnly(matchOnly), .refA(refA), .refB(refB),
    .wordOut(wordOut), .wordOutValid(wordOutValid), .matchFlag(matchFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 time unit after the next rising edge
  task automatic step(input logic v, input logic s, input logic c, input logic [31:0] w);
    @(negedge clk);
    wordValid  = v;
    sofIn      = s;
    clearMatch = c;
    wordIn     = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 flag", {31'd0, matchFlag}, 32'd0);
    check("R11 valid", {31'd0, wordOutValid}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      v = VEC[i];
      modeSel   = v[38:36];
      matchOnly = v[35];
      if (v[39]) step(1'b0, 1'b0, 1'b1, 32'h0);
      step(1'b1, v[34], 1'b0, v[33:2]);
      check($sformatf("R1-7/R10 row %0d flag", i), {31'd0, matchFlag}, {31'd0, v[1]});
      check($sformatf("R9/R10 row %0d valid", i), {31'd0, wordOutValid}, {31'd0, v[0]});
      if (v[0]) check($sformatf("R9 row %0d word", i), wordOut, v[33:2]);
    end

    // R9: idle cycle gives no output word
    matchOnly = 1'b0;
    step(1'b0, 1'b0, 1'b0, 32'h0);
    check("R9 idle valid", {31'd0, wordOutValid}, 32'd0);
    // R8: flag holds over idle cycles
    step(1'b0, 1'b0, 1'b0, 32'h0);
    check("R8 sticky", {31'd0, matchFlag}, 32'd1);
    // R8: clear alone drops flag
    step(1'b0, 1'b0, 1'b1, 32'h0);
    check("R8 clear", {31'd0, matchFlag}, 32'd0);
    // R8: clear together with a new hit keeps flag set
    modeSel = 3'd3;
    step(1'b1, 1'b0, 1'b1, REF_A);
    check("R8 clear+hit", {31'd0, matchFlag}, 32'd1);
    // R1: off mode after clear, matching value still never sets
    step(1'b0, 1'b0, 1'b1, 32'h0);
    modeSel = 3'd0;
    step(1'b1, 1'b1, 1'b0, REF_A);
    step(1'b1, 1'b0, 1'b0, REF_B);
    check("R1 off stays clear", {31'd0, matchFlag}, 32'd0);
    // R10: match-only with matching disabled drops everything
    matchOnly = 1'b1;
    step(1'b1, 1'b0, 1'b0, REF_A);
    check("R10 drop off-mode", {31'd0, wordOutValid}, 32'd0);
    step(1'b0, 1'b0, 1'b0, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        testCount++;
        failCount++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule